// File: doc/BRIEF.md
# Word-Addressed Register Window Router with Byte-Wide EDID Port

This block sits behind one 32-bit, word-addressed memory-mapped slave port and steers each read or write to one of several downstream master ports, selected by the address window that the request falls in. Three of the targets are 32-bit register blocks: a core register block, a video bridge register block and a reserved security register window. Requests to these pass straight through. The address is rebased to the window start, and waitrequest and read data come back from the chosen port.

The fourth target is an EDID RAM that only has an 8-bit port. A 32-bit write to this window is split into four byte writes on consecutive cycles. A 32-bit read is built from four byte reads. The slave waits until all of these byte accesses have finished.

A single-bit host-access flag sits at its own word address. While the flag is set, slave traffic to the EDID window is refused and the RAM sees no strobes. Clearing the flag from 1 to 0 inverts a hotplug output, which prompts the external source to read the EDID again.

Top module: `mm_window_router`

## Requirements
- R1: A request with a word address in 0x400..0x4FF is forwarded to the core port. The read or write strobe is raised, the address is the slave address minus 0x400, and write data is unchanged. All other ports see no strobe, and the slave sees no wait unless the core port inserts one.
- R2: Addresses 0x100..0x1FF go to the video bridge port with offset address minus 0x100. Addresses 0x300..0x3FF go to the security port with offset address minus 0x300. Strobes and write data are forwarded as in R1.
- R3: During a read to a 32-bit window, slave read data and waitrequest are those of the selected port in the same cycle.
- R4: A write to an EDID word w (address 0x000..0x00F) while the flag is clear holds waitrequest high for five cycles and low in the sixth. In cycles 2 to 5 it issues one RAM byte write per cycle, at RAM address 4w+k for lane k = 0..3. Lane k carries data bits 8k+7..8k, so bits 7:0 are written first.
- R5: A read of EDID word w while the flag is clear issues RAM byte reads at 4w+0..4w+3 in cycles 2 to 5. Each byte returns one cycle after its read strobe. In the sixth cycle waitrequest is low and read data is the four bytes assembled little-endian (lane k into bits 8k+7..8k).
- R6: Address 0x200 holds the host-access flag. A write loads bit 0 of write data into the flag, and a read returns the flag in bit 0 with zeros above. Both complete without wait, and the flag drives the edid_host_flag output.
- R7: While the flag is set, an EDID-window access completes in its first cycle. A read returns zero, and neither a RAM read nor a RAM write strobe is issued.
- R8: hotplug_tgl inverts exactly when the flag changes from 1 to 0. Writing 1 over 0, 1 over 1 or 0 over 0 leaves it unchanged.
- R9: An access to any other address completes in its first cycle. A read returns zero, and no downstream port sees a strobe.
- R10: After reset the flag and hotplug_tgl are 0, the serializer is idle and no RAM strobe is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_addr | input | 11 | Slave word address |
| s_read | input | 1 | Slave read request |
| s_write | input | 1 | Slave write request |
| s_wdata | input | 32 | Slave write data |
| s_rdata | output | 32 | Slave read data |
| s_waitreq | output | 1 | Slave waitrequest |
| core_addr | output | 8 | Core port word offset |
| core_read | output | 1 | Core port read strobe |
| core_write | output | 1 | Core port write strobe |
| core_wdata | output | 32 | Core port write data |
| core_rdata | input | 32 | Core port read data |
| core_waitreq | input | 1 | Core port waitrequest |
| vid_addr | output | 8 | Video bridge port word offset |
| vid_read | output | 1 | Video bridge read strobe |
| vid_write | output | 1 | Video bridge write strobe |
| vid_wdata | output | 32 | Video bridge write data |
| vid_rdata | input | 32 | Video bridge read data |
| vid_waitreq | input | 1 | Video bridge waitrequest |
| sec_addr | output | 8 | Security window word offset |
| sec_read | output | 1 | Security window read strobe |
| sec_write | output | 1 | Security window write strobe |
| sec_wdata | output | 32 | Security window write data |
| sec_rdata | input | 32 | Security window read data |
| sec_waitreq | input | 1 | Security window waitrequest |
| ram_addr | output | 6 | EDID RAM byte address |
| ram_we | output | 1 | EDID RAM byte write strobe |
| ram_rd | output | 1 | EDID RAM byte read strobe |
| ram_wdata | output | 8 | EDID RAM write byte |
| ram_rdata | input | 8 | EDID RAM read byte, valid one cycle after ram_rd |
| edid_host_flag | output | 1 | Host-access flag state |
| hotplug_tgl | output | 1 | Hotplug level, inverted when the flag is cleared |

## Verification
Two functions can coincide. The clock edge that clears the host-access flag also inverts the hotplug output, and the very next cycle can already carry an EDID write that must start the byte serializer rather than be refused. The bench clears the flag and, in the following cycle, drives an EDID write with no idle gap. It then judges three things: that hotplug_tgl inverted and the flag reads 0 at that point, that waitrequest is raised in the first cycle of the write, and that the four byte strobes land at the expected RAM addresses with the expected bytes.

// File: rtl/mmr_pkg.sv
package mmr_pkg;
  localparam int NREG     = 3;
  localparam int REG_CORE = 0;
  localparam int REG_VID  = 1;
  localparam int REG_SEC  = 2;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/mmr_decode.sv
module mmr_decode import mmr_pkg::*; #(
  parameter int ADDR_W     = 11,
  parameter int EDID_BASE  = 0,
  parameter int EDID_WORDS = 16,
  parameter int FLAG_ADDR  = 512,
  parameter int REG_WORDS  = 256,
  parameter int CORE_BASE  = 1024,
  parameter int VID_BASE   = 256,
  parameter int SEC_BASE   = 768,
  localparam int REG_AW    = $clog2(REG_WORDS),
  localparam int EDID_WW   = $clog2(EDID_WORDS)
) (
  input  logic [ADDR_W-1:0]             addr,
  output logic                          edid_hit,
  output logic [EDID_WW-1:0]            edid_word,
  output logic                          flag_hit,
  output logic [NREG-1:0]               reg_hit,
  output logic [NREG-1:0][REG_AW-1:0]   reg_off
);
  localparam int BASES [NREG] = '{CORE_BASE, VID_BASE, SEC_BASE};

  logic [NREG-1:0] raw_hit;

  for (genvar g = 0; g < NREG; g++) begin : g_win
    assign raw_hit[g] = (int'(addr) >= BASES[g]) &&
                        (int'(addr) < BASES[g] + REG_WORDS);
    assign reg_off[g] = REG_AW'(addr - ADDR_W'(BASES[g]));
  end

  assign edid_hit  = (int'(addr) >= EDID_BASE) &&
                     (int'(addr) < EDID_BASE + EDID_WORDS);
  assign edid_word = EDID_WW'(addr - ADDR_W'(EDID_BASE));
  assign flag_hit  = (int'(addr) == FLAG_ADDR) && !edid_hit;
  assign reg_hit   = (edid_hit || flag_hit) ? '0 : raw_hit;
endmodule

// File: rtl/mmr_host_flag.sv
module mmr_host_flag (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_bit,
  output logic flag,
  output logic hotplug
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag    <= 1'b0;
      hotplug <= 1'b0;
    end else if (wr_en) begin
      flag <= wr_bit;
      if (flag && !wr_bit) hotplug <= ~hotplug;
    end
  end
endmodule

// File: rtl/mmr_edid_serial.sv
module mmr_edid_serial import mmr_pkg::*; #(
  parameter int DATA_W  = 32,
  parameter int BYTE_W  = 8,
  parameter int WORD_AW = 4,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int LANE_W = $clog2(LANES),
  localparam int RAM_AW = WORD_AW + LANE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic               req_write,
  input  logic [WORD_AW-1:0] req_word,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               wait_o,
  output logic [DATA_W-1:0]  rdata,
  output logic [RAM_AW-1:0]  ram_addr,
  output logic               ram_we,
  output logic               ram_rd,
  output logic [BYTE_W-1:0]  ram_wdata,
  input  logic [BYTE_W-1:0]  ram_rdata
);
  seq_state_e         state_q;
  logic [LANE_W-1:0]  lane_q;
  logic [WORD_AW-1:0] word_q;
  logic [DATA_W-1:0]  wbuf_q;
  logic [DATA_W-1:0]  rbuf_q;
  logic               wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      lane_q  <= '0;
      word_q  <= '0;
      wbuf_q  <= '0;
      rbuf_q  <= '0;
      wr_q    <= 1'b0;
    end else begin
      case (state_q)
        SQ_IDLE: if (req) begin
          state_q <= SQ_RUN;
          lane_q  <= '0;
          word_q  <= req_word;
          wbuf_q  <= req_wdata;
          wr_q    <= req_write;
        end
        SQ_RUN: begin
          if (!wr_q && lane_q != '0)
            rbuf_q <= {ram_rdata, rbuf_q[DATA_W-1:BYTE_W]};
          if (lane_q == LANE_W'(LANES - 1)) state_q <= SQ_DONE;
          else lane_q <= lane_q + 1'b1;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign wait_o    = (state_q == SQ_IDLE) ? req : (state_q == SQ_RUN);
  assign ram_we    = (state_q == SQ_RUN) && wr_q;
  assign ram_rd    = (state_q == SQ_RUN) && !wr_q;
  assign ram_addr  = {word_q, lane_q};
  assign ram_wdata = wbuf_q[lane_q*BYTE_W +: BYTE_W];
  assign rdata     = {ram_rdata, rbuf_q[DATA_W-1:BYTE_W]};
endmodule

// File: rtl/mm_window_router.sv
module mm_window_router import mmr_pkg::*; #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 32,
  parameter int BYTE_W     = 8,
  parameter int EDID_BASE  = 0,
  parameter int EDID_WORDS = 16,
  parameter int FLAG_ADDR  = 512,
  parameter int REG_WORDS  = 256,
  parameter int CORE_BASE  = 1024,
  parameter int VID_BASE   = 256,
  parameter int SEC_BASE   = 768,
  localparam int REG_AW    = $clog2(REG_WORDS),
  localparam int EDID_WW   = $clog2(EDID_WORDS),
  localparam int RAM_AW    = EDID_WW + $clog2(DATA_W / BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic              s_read,
  input  logic              s_write,
  input  logic [DATA_W-1:0] s_wdata,
  output logic [DATA_W-1:0] s_rdata,
  output logic              s_waitreq,
  output logic [REG_AW-1:0] core_addr,
  output logic              core_read,
  output logic              core_write,
  output logic [DATA_W-1:0] core_wdata,
  input  logic [DATA_W-1:0] core_rdata,
  input  logic              core_waitreq,
  output logic [REG_AW-1:0] vid_addr,
  output logic              vid_read,
  output logic              vid_write,
  output logic [DATA_W-1:0] vid_wdata,
  input  logic [DATA_W-1:0] vid_rdata,
  input  logic              vid_waitreq,
  output logic [REG_AW-1:0] sec_addr,
  output logic              sec_read,
  output logic              sec_write,
  output logic [DATA_W-1:0] sec_wdata,
  input  logic [DATA_W-1:0] sec_rdata,
  input  logic              sec_waitreq,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_we,
  output logic              ram_rd,
  output logic [BYTE_W-1:0] ram_wdata,
  input  logic [BYTE_W-1:0] ram_rdata,
  output logic              edid_host_flag,
  output logic              hotplug_tgl
);
  logic                        edid_hit, flag_hit;
  logic [EDID_WW-1:0]          edid_word;
  logic [NREG-1:0]             reg_hit;
  logic [NREG-1:0][REG_AW-1:0] reg_off;
  logic [NREG-1:0]             m_wait;
  logic [NREG-1:0][DATA_W-1:0] m_rdata;
  logic                        edid_req, ser_wait;
  logic [DATA_W-1:0]           ser_rdata;

  mmr_decode #(
    .ADDR_W(ADDR_W), .EDID_BASE(EDID_BASE), .EDID_WORDS(EDID_WORDS),
    .FLAG_ADDR(FLAG_ADDR), .REG_WORDS(REG_WORDS), .CORE_BASE(CORE_BASE),
    .VID_BASE(VID_BASE), .SEC_BASE(SEC_BASE)
  ) u_dec (
    .addr(s_addr), .edid_hit(edid_hit), .edid_word(edid_word),
    .flag_hit(flag_hit), .reg_hit(reg_hit), .reg_off(reg_off)
  );

  // 32-bit pass-through windows
  assign core_addr  = reg_off[REG_CORE];
  assign core_read  = s_read  && reg_hit[REG_CORE];
  assign core_write = s_write && reg_hit[REG_CORE];
  assign core_wdata = s_wdata;
  assign vid_addr   = reg_off[REG_VID];
  assign vid_read   = s_read  && reg_hit[REG_VID];
  assign vid_write  = s_write && reg_hit[REG_VID];
  assign vid_wdata  = s_wdata;
  assign sec_addr   = reg_off[REG_SEC];
  assign sec_read   = s_read  && reg_hit[REG_SEC];
  assign sec_write  = s_write && reg_hit[REG_SEC];
  assign sec_wdata  = s_wdata;

  assign m_wait[REG_CORE]  = core_waitreq;
  assign m_wait[REG_VID]   = vid_waitreq;
  assign m_wait[REG_SEC]   = sec_waitreq;
  assign m_rdata[REG_CORE] = core_rdata;
  assign m_rdata[REG_VID]  = vid_rdata;
  assign m_rdata[REG_SEC]  = sec_rdata;

  mmr_host_flag u_flag (
    .clk(clk), .rst(rst),
    .wr_en(flag_hit && s_write), .wr_bit(s_wdata[0]),
    .flag(edid_host_flag), .hotplug(hotplug_tgl)
  );

  assign edid_req = edid_hit && (s_read || s_write) && !edid_host_flag;

  mmr_edid_serial #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .WORD_AW(EDID_WW)
  ) u_ser (
    .clk(clk), .rst(rst),
    .req(edid_req), .req_write(s_write), .req_word(edid_word),
    .req_wdata(s_wdata), .wait_o(ser_wait), .rdata(ser_rdata),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_rd(ram_rd),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  always_comb begin
    s_rdata   = '0;
    s_waitreq = 1'b0;
    if (edid_hit) begin
      if (!edid_host_flag) begin
        s_waitreq = ser_wait;
        s_rdata   = ser_rdata;
      end
    end else if (flag_hit) begin
      s_rdata[0] = edid_host_flag;
    end else begin
      for (int g = 0; g < NREG; g++) begin
        if (reg_hit[g]) begin
          s_waitreq = m_wait[g];
          s_rdata   = m_rdata[g];
        end
      end
    end
  end
endmodule

// File: rtl/mmr_checker.sv
module mmr_checker #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 32,
  parameter int EDID_WORDS = 16,
  parameter int FLAG_ADDR  = 512,
  parameter int REG_WORDS  = 256,
  parameter int CORE_BASE  = 1024,
  parameter int VID_BASE   = 256,
  parameter int SEC_BASE   = 768,
  parameter int REG_AW     = 8,
  parameter int RAM_AW     = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] s_addr,
  input logic              s_read,
  input logic              s_write,
  input logic [DATA_W-1:0] s_rdata,
  input logic              s_waitreq,
  input logic [REG_AW-1:0] core_addr,
  input logic              core_write,
  input logic [RAM_AW-1:0] ram_addr,
  input logic              ram_we,
  input logic              ram_rd,
  input logic              edid_host_flag,
  input logic              hotplug_tgl
);
  logic in_core, unmapped;
  assign in_core  = int'(s_addr) >= CORE_BASE && int'(s_addr) < CORE_BASE + REG_WORDS;
  assign unmapped = !(int'(s_addr) < EDID_WORDS) && int'(s_addr) != FLAG_ADDR && !in_core &&
                    !(int'(s_addr) >= VID_BASE && int'(s_addr) < VID_BASE + REG_WORDS) &&
                    !(int'(s_addr) >= SEC_BASE && int'(s_addr) < SEC_BASE + REG_WORDS);

  assert_core_route_R1: assert property (@(posedge clk) disable iff (rst)
    (s_write && in_core) |-> (core_write && core_addr == REG_AW'(s_addr - ADDR_W'(CORE_BASE))));

  assert_ram_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && ram_rd));

  assert_ram_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
    (ram_we && $past(ram_we)) |-> (ram_addr == $past(ram_addr) + 1'b1));

  assert_flag_blocks_ram_R7: assert property (@(posedge clk) disable iff (rst)
    edid_host_flag |-> (!ram_we && !ram_rd));

  assert_hotplug_on_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (hotplug_tgl != $past(hotplug_tgl)) |-> ($past(edid_host_flag) && !edid_host_flag));

  assert_unmapped_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    ((s_read || s_write) && unmapped) |-> (!s_waitreq && (s_rdata == '0 || !s_read)));
endmodule

bind mm_window_router mmr_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EDID_WORDS(EDID_WORDS),
  .FLAG_ADDR(FLAG_ADDR), .REG_WORDS(REG_WORDS), .CORE_BASE(CORE_BASE),
  .VID_BASE(VID_BASE), .SEC_BASE(SEC_BASE), .REG_AW(REG_AW), .RAM_AW(RAM_AW)
) u_mmr_checker (
  .clk(clk), .rst(rst), .s_addr(s_addr), .s_read(s_read), .s_write(s_write),
  .s_rdata(s_rdata), .s_waitreq(s_waitreq), .core_addr(core_addr),
  .core_write(core_write), .ram_addr(ram_addr), .ram_we(ram_we),
  .ram_rd(ram_rd), .edid_host_flag(edid_host_flag), .hotplug_tgl(hotplug_tgl)
);

// File: tb/test_mm_window_router.sv
module test_mm_window_router;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] s_addr = '0;
  logic        s_read = 1'b0, s_write = 1'b0;
  logic [31:0] s_wdata = '0;
  logic [31:0] s_rdata;
  logic        s_waitreq;
  logic [7:0]  core_addr, vid_addr, sec_addr;
  logic        core_read, core_write, vid_read, vid_write, sec_read, sec_write;
  logic [31:0] core_wdata, vid_wdata, sec_wdata, core_rdata, vid_rdata, sec_rdata;
  logic        core_waitreq = 1'b0, vid_waitreq = 1'b0, sec_waitreq = 1'b0;
  logic [5:0]  ram_addr;
  logic        ram_we, ram_rd;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = '0;
  logic        edid_host_flag, hotplug_tgl;
  logic [7:0]  mem [64];
  int          n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign core_rdata = 32'hC0DE_0000 | {24'h0, core_addr};
  assign vid_rdata  = 32'hB1DE_0000 | {24'h0, vid_addr};
  assign sec_rdata  = 32'h5EC0_0000 | {24'h0, sec_addr};

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_rd) ram_rdata <= mem[ram_addr];
  end

  mm_window_router i_mm_window_router (.*);

  // op(1) addr(11) data(32) target(2: 0 core,1 vid,2 sec,3 none) offset(8)
  localparam logic [53:0] VEC [NVEC] = '{
    {1'b1, 11'h400, 32'hDEADBEEF, 2'd0, 8'h00},
    {1'b1, 11'h4FF, 32'h12345678, 2'd0, 8'hFF},
    {1'b0, 11'h4A5, 32'h0,        2'd0, 8'hA5},
    {1'b1, 11'h100, 32'hCAFEF00D, 2'd1, 8'h00},
    {1'b0, 11'h1FF, 32'h0,        2'd1, 8'hFF},
    {1'b1, 11'h305, 32'h0BADC0DE, 2'd2, 8'h05},
    {1'b0, 11'h3FE, 32'h0,        2'd2, 8'hFE},
    {1'b0, 11'h500, 32'h0,        2'd3, 8'h00},
    {1'b1, 11'h7FF, 32'h11111111, 2'd3, 8'h00},
    {1'b0, 11'h010, 32'h0,        2'd3, 8'h00},
    {1'b0, 11'h201, 32'h0,        2'd3, 8'h00}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] strobes();
    return {core_write, core_read, vid_write, vid_read, sec_write, sec_read, ram_we, ram_rd};
  endfunction

  // tasks start right after a negedge and return at a later negedge, bus idle
  task automatic bus_write(input logic [10:0] a, input logic [31:0] d);
    s_addr = a; s_wdata = d; s_write = 1'b1;
    @(negedge clk); s_write = 1'b0;
  endtask

  task automatic bus_read(input logic [10:0] a, input logic [31:0] exp, input string req);
    s_addr = a; s_read = 1'b1; #1;
    check(!s_waitreq && s_rdata == exp, req, s_rdata, exp);
    @(negedge clk); s_read = 1'b0;
  endtask

  task automatic edid_write(input logic [3:0] w, input logic [31:0] d);
    s_addr = {7'h0, w}; s_wdata = d; s_write = 1'b1; #1;
    check(s_waitreq, "R4 wait first cycle", {31'h0, s_waitreq}, 32'h1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      check(ram_we && !ram_rd && ram_addr == {w, 2'(k)} && ram_wdata == d[8*k +: 8] && s_waitreq,
            "R4 byte write", {16'h0, ram_addr, ram_we, s_waitreq, ram_wdata},
            {16'h0, w, 2'(k), 1'b1, 1'b1, d[8*k +: 8]});
    end
    @(negedge clk); #1;
    check(!s_waitreq && !ram_we, "R4 done cycle", {30'h0, s_waitreq, ram_we}, 32'h0);
    s_write = 1'b0;
    @(negedge clk);
  endtask

  task automatic edid_read(input logic [3:0] w, input logic [31:0] exp);
    s_addr = {7'h0, w}; s_read = 1'b1; #1;
    check(s_waitreq, "R5 wait first cycle", {31'h0, s_waitreq}, 32'h1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      check(ram_rd && !ram_we && ram_addr == {w, 2'(k)} && s_waitreq, "R5 byte read",
            {24'h0, ram_addr, ram_rd, s_waitreq}, {24'h0, w, 2'(k), 2'b11});
    end
    @(negedge clk); #1;
    check(!s_waitreq && s_rdata == exp, "R5 assembled word", s_rdata, exp);
    s_read = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] mem_word(input int w);
    return {mem[4*w+3], mem[4*w+2], mem[4*w+1], mem[4*w]};
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  exp_str;
    logic [31:0] exp_rd;
    logic        hp;
    for (int i = 0; i < 64; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R10: reset state
    check(!edid_host_flag && !hotplug_tgl && !ram_we && !ram_rd, "R10 reset state",
          {28'h0, edid_host_flag, hotplug_tgl, ram_we, ram_rd}, 32'h0);

    // vector walk: R1 core, R2 video/security, R3 read data, R9 unmapped
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      s_addr = VEC[v][52:42]; s_wdata = VEC[v][41:10];
      s_write = VEC[v][53]; s_read = !VEC[v][53];
      #1;
      exp_str = '0;
      if (VEC[v][9:8] != 2'd3) exp_str[7 - 2*VEC[v][9:8] - (VEC[v][53] ? 0 : 1)] = 1'b1;
      check(strobes() == exp_str, VEC[v][9:8] == 3 ? "R9 strobes" : (VEC[v][9:8] == 0 ? "R1 strobes" : "R2 strobes"),
            {24'h0, strobes()}, {24'h0, exp_str});
      case (VEC[v][9:8])
        2'd0: check(core_addr == VEC[v][7:0] && (!VEC[v][53] || core_wdata == VEC[v][41:10]),
                    "R1 offset/data", {core_addr, core_wdata[23:0]}, {VEC[v][7:0], VEC[v][33:10]});
        2'd1: check(vid_addr == VEC[v][7:0] && (!VEC[v][53] || vid_wdata == VEC[v][41:10]),
                    "R2 video offset/data", {vid_addr, vid_wdata[23:0]}, {VEC[v][7:0], VEC[v][33:10]});
        2'd2: check(sec_addr == VEC[v][7:0] && (!VEC[v][53] || sec_wdata == VEC[v][41:10]),
                    "R2 security offset/data", {sec_addr, sec_wdata[23:0]}, {VEC[v][7:0], VEC[v][33:10]});
        default: check(!s_waitreq, "R9 no wait", {31'h0, s_waitreq}, 32'h0);
      endcase
      if (!VEC[v][53]) begin
        case (VEC[v][9:8])
          2'd0: exp_rd = 32'hC0DE_0000 | {24'h0, VEC[v][7:0]};
          2'd1: exp_rd = 32'hB1DE_0000 | {24'h0, VEC[v][7:0]};
          2'd2: exp_rd = 32'h5EC0_0000 | {24'h0, VEC[v][7:0]};
          default: exp_rd = 32'h0;
        endcase
        check(s_rdata == exp_rd && !s_waitreq, VEC[v][9:8] == 3 ? "R9 read zero" : "R3 read data", s_rdata, exp_rd);
      end
    end
    @(negedge clk); s_read = 1'b0; s_write = 1'b0;

    // R3: waitrequest from the selected port is passed back
    core_waitreq = 1'b1; s_addr = 11'h410; s_read = 1'b1; #1;
    check(s_waitreq == 1'b1, "R3 waitreq passthrough", {31'h0, s_waitreq}, 32'h1);
    @(negedge clk); s_read = 1'b0; core_waitreq = 1'b0;
    @(negedge clk);

    // R4 / R5: serialized EDID accesses
    edid_write(4'd3, 32'h44332211);
    check(mem_word(3) == 32'h44332211, "R4 ram contents", mem_word(3), 32'h44332211);
    edid_read(4'd3, 32'h44332211);
    exp_rd = mem_word(5);
    edid_read(4'd5, exp_rd);
    edid_write(4'd15, 32'h89ABCDEF);
    check(mem_word(15) == 32'h89ABCDEF, "R4 last word", mem_word(15), 32'h89ABCDEF);

    // R6: flag set and read back
    hp = hotplug_tgl;
    bus_write(11'h200, 32'hFFFF_FFFF); #1;
    check(edid_host_flag == 1'b1, "R6 flag set", {31'h0, edid_host_flag}, 32'h1);
    check(hotplug_tgl == hp, "R8 no toggle on set", {31'h0, hotplug_tgl}, {31'h0, hp});
    bus_read(11'h200, 32'h1, "R6 flag read");
    bus_write(11'h200, 32'h1); #1;
    check(hotplug_tgl == hp, "R8 no toggle on 1 over 1", {31'h0, hotplug_tgl}, {31'h0, hp});

    // R7: EDID traffic blocked while flag set
    exp_rd = mem_word(2);
    s_addr = 11'h002; s_wdata = 32'hFFFF_FFFF; s_write = 1'b1; #1;
    check(!s_waitreq && !ram_we && !ram_rd, "R7 blocked write",
          {29'h0, s_waitreq, ram_we, ram_rd}, 32'h0);
    @(negedge clk); s_write = 1'b0; #1;
    check(!ram_we && !ram_rd, "R7 no later strobes", {30'h0, ram_we, ram_rd}, 32'h0);
    @(negedge clk);
    check(mem_word(2) == exp_rd, "R7 ram unchanged", mem_word(2), exp_rd);
    bus_read(11'h003, 32'h0, "R7 blocked read zero");

    // R8 with R4: clear flag, then EDID write in the very next cycle
    bus_write(11'h200, 32'h0); #1;
    check(!edid_host_flag && hotplug_tgl == !hp, "R8 toggle on clear",
          {30'h0, edid_host_flag, hotplug_tgl}, {30'h0, 1'b0, !hp});
    edid_write(4'd2, 32'hA1B2C3D4);
    check(mem_word(2) == 32'hA1B2C3D4, "R4 write after clear", mem_word(2), 32'hA1B2C3D4);
    hp = hotplug_tgl;
    bus_write(11'h200, 32'h0); #1;
    check(hotplug_tgl == hp, "R8 no toggle on 0 over 0", {31'h0, hotplug_tgl}, {31'h0, hp});

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule